// File: doc/BRIEF.md
# Packet Receive FIFO with Burst Request

This block buffers received packet words between a MAC-side writer and a host bus reader. Each stored entry holds one data word and a flag that marks the last word of a packet. The reader sees the oldest entry at the read port at all times, and pops it with a read strobe. The end-of-packet flag comes out of the read port together with its word.

The block raises a packet-available request toward the host bus logic in two cases. The first is when enough words are stored to fill one bus burst, where the burst size is chosen among 4, 8 and 16 words. The second is when at least one end-of-packet entry sits in the queue. The second case flushes packets whose length is not a multiple of the burst, and runt packets, without waiting for more data. The host reader starts a burst only after the request is raised, so the queue is never read past its contents.

If the writer pushes a word while the queue is full, the word is discarded and a sticky overrun flag is set. The flag stays set until the host sends a clear pulse.

Top module: `rxq_burst_fifo`

## Requirements
- R1: After reset the queue is empty, `pkt_avail` is 0 and `ovr_err` is 0.
- R2: Words leave the read port in the order they were accepted, and each word keeps its own `wr_eop` value as `rd_eop`. `rd_data` and `rd_eop` always show the oldest stored entry.
- R3: `burst_sel` picks the burst size: 2'b00 means 4 words, 2'b01 means 8 words and 2'b10 means 16 words. Without a stored end-of-packet entry, `pkt_avail` is 1 exactly when the number of stored words is at least that size.
- R4: `burst_sel` = 2'b11 behaves like 2'b10, so the burst size is 16 words.
- R5: While at least one stored entry carries the end-of-packet flag, `pkt_avail` is 1 whatever the word count. It stays 1 until that entry has been read out.
- R6: A write made while the queue holds DEPTH (32) words is dropped, and the stored contents stay unchanged. From the next cycle `ovr_err` is 1, and it stays 1 while `ovr_clr` is low. A read in the same cycle does not make room for that write.
- R7: An `ovr_clr` pulse clears `ovr_err` on the next cycle. If a dropped write falls in the same cycle as the clear, the set wins.
- R8: A read strobe on an empty queue is ignored. When a write and a read fall in the same cycle on a queue that is neither empty nor full, both take effect and the word count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Writer strobe: push one entry |
| wr_data | input | 32 | Word to push |
| wr_eop | input | 1 | The pushed word ends a packet |
| rd_en | input | 1 | Reader strobe: pop the oldest entry |
| rd_data | output | 32 | Oldest stored word |
| rd_eop | output | 1 | End-of-packet flag of the oldest stored word |
| burst_sel | input | 2 | Burst size select (00:4, 01:8, 10:16, 11:16) |
| pkt_avail | output | 1 | Request to the host bus reader |
| ovr_clr | input | 1 | Clear pulse for the overrun flag |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
Two functions can land in the same cycle. A write can be dropped on a full queue while `ovr_clr` clears the overrun flag, and a read can pop the last end-of-packet entry while a write pushes a new one. The bench fills the queue and issues a write, a read and a clear together. It then expects the flag to stay set, the written word to be absent from the read stream, and the request to follow the end-of-packet count as it stands after both updates. A random phase repeats these collisions many times against a queue model in the bench.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef enum logic [1:0] {
      BURST_4   = 2'b00,
      BURST_8   = 2'b01,
      BURST_16  = 2'b10,
      BURST_16X = 2'b11
   } burst_sel_e;

   localparam int unsigned MAX_BURST = 16;

   // Number of words that make up one bus burst for a given select code.
   function automatic int unsigned burst_words(input logic [1:0] sel);
      case (burst_sel_e'(sel))
         BURST_4:  return 4;
         BURST_8:  return 8;
         default:  return MAX_BURST;
      endcase
   endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int unsigned ENTRY_W = 33,
   parameter int unsigned DEPTH   = 32,
   localparam int unsigned PTR_W  = $clog2(DEPTH),
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [ENTRY_W-1:0] push_entry,
   input  logic               pop,
   output logic [ENTRY_W-1:0] head_entry,
   output logic [CNT_W-1:0]   occ,
   output logic               full,
   output logic               empty
);

   logic [PTR_W-1:0]   wr_ptr;
   logic [PTR_W-1:0]   rd_ptr;
   logic [ENTRY_W-1:0] rows [DEPTH];

   // One register row per entry, each with its own decoded write enable.
   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
      logic row_we;
      assign row_we = push && (wr_ptr == PTR_W'(gi));
      always_ff @(posedge clk) begin
         if (row_we) rows[gi] <= push_entry;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   assign head_entry = rows[rd_ptr];
   assign full       = (occ == CNT_W'(DEPTH));
   assign empty      = (occ == '0);

endmodule

// File: rtl/rxq_eop_track.sv
module rxq_eop_track #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eop_in,
   input  logic             eop_out,
   output logic [CNT_W-1:0] eop_cnt
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eop_cnt <= '0;
      end else begin
         case ({eop_in, eop_out})
            2'b10:   eop_cnt <= eop_cnt + 1'b1;
            2'b01:   eop_cnt <= eop_cnt - 1'b1;
            default: eop_cnt <= eop_cnt;
         endcase
      end
   end

endmodule

// File: rtl/rxq_req_gen.sv
module rxq_req_gen
   import rxq_pkg::*;
#(
   parameter int unsigned CNT_W = 6
) (
   input  logic [CNT_W-1:0] occ,
   input  logic [CNT_W-1:0] eop_cnt,
   input  logic [1:0]       burst_sel,
   output logic             pkt_avail
);

   logic [CNT_W-1:0] thr;
   logic             burst_ready;
   logic             eop_ready;

   assign thr         = CNT_W'(burst_words(burst_sel));
   assign burst_ready = (occ >= thr);
   assign eop_ready   = (eop_cnt != '0);
   assign pkt_avail   = burst_ready || eop_ready;

endmodule

// File: rtl/rxq_ovr_flag.sv
module rxq_ovr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic drop,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk) begin
      if (!rst_n)    flag <= 1'b0;
      else if (drop) flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end

endmodule

// File: rtl/rxq_burst_fifo.sv
module rxq_burst_fifo
   import rxq_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_eop,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_eop,
   input  logic [1:0]        burst_sel,
   output logic              pkt_avail,
   input  logic              ovr_clr,
   output logic              ovr_err
);

   localparam int unsigned ENTRY_W = DATA_W + 1;
   localparam int unsigned CNT_W   = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= MAX_BURST)
         else $error("DEPTH must hold at least one largest burst");
      assert ((DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two");
      assert (DATA_W >= 1)
         else $error("DATA_W must be positive");
   end

   logic               full;
   logic               empty;
   logic               wr_ok;
   logic               rd_ok;
   logic               wr_drop;
   logic [ENTRY_W-1:0] head_entry;
   logic [CNT_W-1:0]   occ;
   logic [CNT_W-1:0]   eop_cnt;

   // Acceptance depends only on the state at the start of the cycle.
   assign wr_ok   = wr_en && !full;
   assign wr_drop = wr_en && full;
   assign rd_ok   = rd_en && !empty;

   rxq_store #(
      .ENTRY_W (ENTRY_W),
      .DEPTH   (DEPTH)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (wr_ok),
      .push_entry ({wr_eop, wr_data}),
      .pop        (rd_ok),
      .head_entry (head_entry),
      .occ        (occ),
      .full       (full),
      .empty      (empty)
   );

   assign rd_data = head_entry[DATA_W-1:0];
   assign rd_eop  = head_entry[DATA_W];

   rxq_eop_track #(
      .CNT_W (CNT_W)
   ) u_eop (
      .clk     (clk),
      .rst_n   (rst_n),
      .eop_in  (wr_ok && wr_eop),
      .eop_out (rd_ok && rd_eop),
      .eop_cnt (eop_cnt)
   );

   rxq_req_gen #(
      .CNT_W (CNT_W)
   ) u_req (
      .occ       (occ),
      .eop_cnt   (eop_cnt),
      .burst_sel (burst_sel),
      .pkt_avail (pkt_avail)
   );

   rxq_ovr_flag u_ovr (
      .clk   (clk),
      .rst_n (rst_n),
      .drop  (wr_drop),
      .clr   (ovr_clr),
      .flag  (ovr_err)
   );

endmodule

// File: rtl/rxq_burst_fifo_chk.sv
module rxq_burst_fifo_chk #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [1:0]       burst_sel,
   input logic             ovr_clr,
   input logic             ovr_err,
   input logic             pkt_avail,
   input logic [CNT_W-1:0] occ,
   input logic [CNT_W-1:0] eop_cnt
);

   logic [CNT_W-1:0] exp_thr;
   always_comb begin
      case (burst_sel)
         2'b00:   exp_thr = CNT_W'(4);
         2'b01:   exp_thr = CNT_W'(8);
         default: exp_thr = CNT_W'(16);
      endcase
   end

   p_reset_clean_r1: assert property (@(posedge clk)
      !rst_n |=> (occ == '0) && !ovr_err);

   p_thr_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (occ >= exp_thr) |-> pkt_avail);

   p_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (occ < exp_thr) && (eop_cnt == '0) |-> !pkt_avail);

   p_eop_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eop_cnt != '0) |-> pkt_avail);

   p_drop_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (occ == CNT_W'(DEPTH)) |=> ovr_err);

   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CNT_W'(DEPTH));

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_err && !ovr_clr |=> ovr_err);

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_clr && !(wr_en && (occ == CNT_W'(DEPTH))) |=> !ovr_err);

   p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) && rd_en && !wr_en |=> (occ == '0));

   p_eop_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eop_cnt <= occ);

endmodule

bind rxq_burst_fifo rxq_burst_fifo_chk #(
   .DEPTH (DEPTH),
   .CNT_W (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .burst_sel (burst_sel),
   .ovr_clr   (ovr_clr),
   .ovr_err   (ovr_err),
   .pkt_avail (pkt_avail),
   .occ       (occ),
   .eop_cnt   (eop_cnt)
);

// File: tb/test_rxq_burst_fifo.sv
`timescale 1ns/1ps
module test_rxq_burst_fifo;

   localparam int unsigned DEPTH = 32;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [31:0] wr_data;
   logic        wr_eop;
   logic        rd_en;
   logic [31:0] rd_data;
   logic        rd_eop;
   logic [1:0]  burst_sel;
   logic        pkt_avail;
   logic        ovr_clr;
   logic        ovr_err;

   int unsigned total = 0;
   int unsigned bad   = 0;
   bit          finished = 1'b0;

   bit [32:0] mq [$];
   bit        m_ovr;

   always #5 clk = ~clk;

   rxq_burst_fifo i_rxq_burst_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .wr_eop    (wr_eop),
      .rd_en     (rd_en),
      .rd_data   (rd_data),
      .rd_eop    (rd_eop),
      .burst_sel (burst_sel),
      .pkt_avail (pkt_avail),
      .ovr_clr   (ovr_clr),
      .ovr_err   (ovr_err)
   );

   function automatic int unsigned sel_words(input logic [1:0] s);
      if (s == 2'b00) return 4;
      if (s == 2'b01) return 8;
      return 16;
   endfunction

   function automatic int unsigned model_eops();
      int unsigned n = 0;
      foreach (mq[i]) if (mq[i][32]) n++;
      return n;
   endfunction

   function automatic bit exp_avail(input logic [1:0] s);
      return (mq.size() >= sel_words(s)) || (model_eops() != 0);
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic compare_all(input bit clr_used);
      string lbl;
      if (model_eops() != 0)     lbl = "R5";
      else if (burst_sel == 2'b11) lbl = "R4";
      else                        lbl = "R3";
      check({lbl, " pkt_avail"}, 64'(pkt_avail), 64'(exp_avail(burst_sel)));
      check(clr_used ? "R7 ovr_err" : "R6 ovr_err", 64'(ovr_err), 64'(m_ovr));
      if (mq.size() != 0) begin
         check("R2 rd_data", 64'(rd_data), 64'(mq[0][31:0]));
         check("R2 rd_eop", 64'(rd_eop), 64'(mq[0][32]));
      end
   endtask

   // Drive one cycle at the falling edge, update the model at the rising
   // edge from the pre-edge state, compare at the next falling edge.
   task automatic step(input bit we, input logic [31:0] d, input bit eop,
                       input bit re, input bit clr);
      bit full_m;
      bit [32:0] head;
      wr_en = we; wr_data = d; wr_eop = eop; rd_en = re; ovr_clr = clr;
      @(posedge clk);
      full_m = (mq.size() == DEPTH);
      if (re && mq.size() != 0) head = mq.pop_front();
      if (we && !full_m) mq.push_back({eop, d});
      if (we && full_m) m_ovr = 1'b1;
      else if (clr)     m_ovr = 1'b0;
      @(negedge clk);
      compare_all(clr);
   endtask

   task automatic idle();
      step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_eop = 1'b0;
      rd_en = 1'b0; ovr_clr = 1'b0; burst_sel = 2'b00;
      m_ovr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1 pkt_avail", 64'(pkt_avail), 64'(0));
      check("R1 ovr_err", 64'(ovr_err), 64'(0));

      // R8: read on empty is ignored, then a write is read back intact
      step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
      step(1'b1, 32'hA5A5_0001, 1'b0, 1'b0, 1'b0);
      check("R8 rd_data after empty read", 64'(rd_data), 64'(32'hA5A5_0001));
      step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);

      // R3: 4-word burst boundary
      burst_sel = 2'b00;
      for (int i = 0; i < 4; i++) step(1'b1, 32'h100 + i, 1'b0, 1'b0, 1'b0);
      check("R3 four words", 64'(pkt_avail), 64'(1));
      // R8: write and read together keep the count
      step(1'b1, 32'h200, 1'b0, 1'b1, 1'b0);
      check("R8 count kept", 64'(pkt_avail), 64'(1));
      step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
      check("R3 three words", 64'(pkt_avail), 64'(0));
      // R3: 8-word select
      burst_sel = 2'b01;
      for (int i = 0; i < 4; i++) step(1'b1, 32'h300 + i, 1'b0, 1'b0, 1'b0);
      check("R3 seven words sel8", 64'(pkt_avail), 64'(0));
      step(1'b1, 32'h310, 1'b0, 1'b0, 1'b0);
      check("R3 eight words sel8", 64'(pkt_avail), 64'(1));
      // R4: code 11 means 16
      burst_sel = 2'b11;
      for (int i = 0; i < 7; i++) step(1'b1, 32'h400 + i, 1'b0, 1'b0, 1'b0);
      check("R4 fifteen words", 64'(pkt_avail), 64'(0));
      step(1'b1, 32'h410, 1'b0, 1'b0, 1'b0);
      check("R4 sixteen words", 64'(pkt_avail), 64'(1));
      while (mq.size() != 0) step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);

      // R5: runt packet flushes early, request holds until eop word leaves
      burst_sel = 2'b10;
      step(1'b1, 32'h500, 1'b0, 1'b0, 1'b0);
      step(1'b1, 32'h501, 1'b1, 1'b0, 1'b0);
      check("R5 runt request", 64'(pkt_avail), 64'(1));
      step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
      check("R5 held before eop read", 64'(pkt_avail), 64'(1));
      // read the eop word while a new eop word arrives
      step(1'b1, 32'h502, 1'b1, 1'b1, 1'b0);
      check("R5 new eop keeps request", 64'(pkt_avail), 64'(1));
      step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
      check("R5 request drops", 64'(pkt_avail), 64'(0));

      // R6: overrun on full queue, with read and clear in the same cycle
      for (int i = 0; i < DEPTH; i++) step(1'b1, 32'h600 + i, 1'b0, 1'b0, 1'b0);
      step(1'b1, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1);
      check("R7 set wins over clear", 64'(ovr_err), 64'(1));
      idle();
      check("R6 sticky", 64'(ovr_err), 64'(1));
      step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
      check("R7 cleared", 64'(ovr_err), 64'(0));
      while (mq.size() != 0) step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);

      // Random phase
      for (int n = 0; n < 6000; n++) begin
         int unsigned wp;
         if (n % 500 == 0) burst_sel = 2'($urandom());
         wp = ((n / 700) % 2 == 0) ? 70 : 35;
         step(($urandom() % 100) < wp, $urandom(), ($urandom() % 9) == 0,
              ($urandom() % 100) < 50, ($urandom() % 40) == 0);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule